// File: doc/BRIEF.md
# Timer Input Edge Qualifier

This block takes a raw, asynchronous timer input pin and turns it into a filtered level and single-cycle edge strobes. A timer uses the strobes either as its count clock or as a capture trigger. The pin is first brought into the system clock domain by a two-flop synchronizer. After that, a level history decides when the input has really changed.

In count-clock mode the history follows the synchronized pin on every system clock. In capture mode it only looks at the pin when the external sample enable is high. This enable stands in for a prescaler tap. A new level is accepted only when two successive sample points agree on it, so short pulses are dropped as noise.

When the block is started, the history is loaded with the inverse of the synchronized pin. This produces the expected edge right after start-up. The pin can also be handed over to a timer output function. While that is selected, the input path behaves as if stopped.

Top module: `tin_edge_qual`

## Requirements
- R1: In count-clock mode, a pin change reaches `level_o` on the third rising clock edge after it is applied. This delay is two synchronizer flops plus the history register.
- R2: `edge_sel_i` bit 0 enables rising-edge strobes and bit 1 enables falling-edge strobes. The value 2'b00 gives no strobes and 2'b11 gives both.
- R3: `edge_o` stays high for exactly one clock cycle. It rises on the clock edge after the one on which `level_o` changed, in the direction shown by the new level.
- R4: In capture mode (`capture_mode_i`=1), a new level is accepted only when two consecutive sample points both show it. A pin pulse seen by fewer than two sample points changes neither the level nor the strobe.
- R5: In capture mode, the history moves only on cycles where `sample_en_i` is high. In count-clock mode, `sample_en_i` has no effect.
- R6: On the first cycle of operation (run rising, including the first start after reset), the history is loaded with the inverse of the synchronized pin. As a result, a rising strobe follows at once if the pin is high and rising edges are selected. A falling strobe follows at once if the pin is low and falling edges are selected.
- R7: While `run_i` is low, `edge_o` is 0 from the next clock edge on and `level_o` holds its value.
- R8: While `out_fn_i` is high, the input path acts as stopped. No strobes are produced and `level_o` holds.
- R9: After reset, `edge_o` and `level_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous timer input pin |
| run_i | input | 1 | Timer run enable |
| edge_sel_i | input | 2 | Bit 0 selects rising edges, bit 1 selects falling edges |
| capture_mode_i | input | 1 | 0 selects count-clock use (sample every cycle), 1 selects capture use (filtered, sample enable) |
| sample_en_i | input | 1 | Prescaler sample tick, used only in capture mode |
| out_fn_i | input | 1 | Pin is assigned to the timer output function |
| edge_o | output | 1 | One-cycle valid-edge strobe |
| level_o | output | 1 | Filtered input level |

## Verification
The hardest behaviour to reach is noise rejection in capture mode. It needs a pin pulse that is long enough to pass the synchronizer, yet seen by only one sample point. The bench sets the sample enable to fire once every four cycles and applies a two-cycle pulse. It then checks that neither the level nor the strobe moves, and that a long pulse is still accepted in both directions. The start-up edge is reached by sweeping every edge selection, both modes and both pin levels through a stop-and-restart sequence. Each run checks the number of strobes and the cycle of the first one.

// File: rtl/tin_edge_qual.sv
module tin_edge_qual (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       run_i,
  input  logic [1:0] edge_sel_i,
  input  logic       capture_mode_i,
  input  logic       sample_en_i,
  input  logic       out_fn_i,
  output logic       edge_o,
  output logic       level_o
);

  logic sync1, sync2;
  logic hist, hist_d, cand, running, strobe;
  logic active, accept, dir_ok;

  assign active = run_i & ~out_fn_i;
  assign accept = capture_mode_i ? (sample_en_i & (sync2 == cand) & (sync2 != hist))
                                 : (sync2 != hist);
  assign dir_ok = hist ? edge_sel_i[0] : edge_sel_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= 1'b0;
      hist_d  <= 1'b0;
      cand    <= 1'b0;
      running <= 1'b0;
      strobe  <= 1'b0;
    end else if (!active) begin
      running <= 1'b0;
      strobe  <= 1'b0;
    end else if (!running) begin
      running <= 1'b1;
      hist    <= ~sync2;
      hist_d  <= ~sync2;
      cand    <= ~sync2;
      strobe  <= 1'b0;
    end else begin
      if (accept) hist <= sync2;
      if (capture_mode_i && sample_en_i) cand <= sync2;
      hist_d <= hist;
      strobe <= (hist != hist_d) & dir_ok;
    end
  end

  assign edge_o  = strobe;
  assign level_o = hist;

endmodule

module tin_edge_qual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_i,
  input logic [1:0] edge_sel_i,
  input logic       capture_mode_i,
  input logic       sample_en_i,
  input logic       out_fn_i,
  input logic       running,
  input logic       edge_o,
  input logic       level_o
);

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o); // R3

  AST_STROBE_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> ($past(level_o) != $past(level_o, 2))); // R3

  AST_STROBE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> ($past(level_o) ? $past(edge_sel_i[0]) : $past(edge_sel_i[1]))); // R2

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!edge_o && $stable(level_o))); // R7

  AST_OUTFN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_fn_i |=> (!edge_o && $stable(level_o))); // R8

  AST_CAPTURE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_mode_i && run_i && !out_fn_i && running && !sample_en_i) |=> $stable(level_o)); // R5

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!edge_o && !level_o); // R9

endmodule

bind tin_edge_qual tin_edge_qual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .edge_sel_i(edge_sel_i),
  .capture_mode_i(capture_mode_i), .sample_en_i(sample_en_i), .out_fn_i(out_fn_i),
  .running(running), .edge_o(edge_o), .level_o(level_o)
);

// File: tb/test_tin_edge_qual.sv
module test_tin_edge_qual;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, run = 1'b0, cap = 1'b0, se = 1'b1, ofn = 1'b0;
  logic [1:0] sel = 2'b00;
  logic edge_o, level_o;

  int vectors = 0, errors = 0, cyc = 0;
  bit slow = 1'b0;
  int n_rise, n_high, first;
  logic prev_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  tin_edge_qual i_tin_edge_qual (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .run_i(run), .edge_sel_i(sel),
    .capture_mode_i(cap), .sample_en_i(se), .out_fn_i(ofn),
    .edge_o(edge_o), .level_o(level_o)
  );

  task automatic tick();
    @(negedge clk);
    cyc++;
    se = slow ? (cyc % 4 == 0) : 1'b1;
  endtask

  task automatic watch(input int n);
    n_rise = 0; n_high = 0; first = 0; prev_e = 1'b0;
    for (int i = 1; i <= n; i++) begin
      tick();
      if (edge_o) begin
        n_high++;
        if (!prev_e) begin
          n_rise++;
          if (first == 0) first = i;
        end
      end
      prev_e = edge_o;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic held;
    logic p0;
    tick(); tick();
    check("R9 edge after reset", edge_o, 0);
    check("R9 level after reset", level_o, 0);
    rst_n = 1'b1;
    tick();

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 2; p++) begin
          p0 = p[0];
          run = 1'b0;
          slow = (m == 0);
          cap = m[0];
          sel = s[1:0];
          held = level_o;
          pin = p0;
          watch(6);
          check("R7 no strobe while stopped", n_high, 0);
          check("R7 level held while stopped", level_o, held);
          run = 1'b1;
          watch(8);
          check("R6 start strobe count", n_rise, (p0 ? s[0] : s[1]));
          check("R3 start strobe width", n_high, n_rise);
          if (n_rise != 0) check("R6 start strobe cycle", first, (m == 1) ? 4 : 3);
          check("R1 level after start", level_o, p0);
          pin = ~p0;
          watch(8);
          check("R2 toggle strobe count", n_rise, (!p0 ? s[0] : s[1]));
          check("R3 toggle strobe width", n_high, n_rise);
          if (n_rise != 0) check("R1 toggle strobe cycle", first, (m == 1) ? 5 : 4);
          check("R1 level after toggle", level_o, !p0);
        end

    run = 1'b0; slow = 1'b1; cap = 1'b1; sel = 2'b11; pin = 1'b0;
    watch(6);
    run = 1'b1;
    watch(16);
    check("R4 capture settle level", level_o, 0);
    pin = 1'b1; tick(); tick(); pin = 1'b0;
    watch(20);
    check("R4 short pulse rejected strobes", n_high, 0);
    check("R4 short pulse rejected level", level_o, 0);
    pin = 1'b1;
    watch(16);
    check("R4 long pulse accepted level", level_o, 1);
    check("R5 long pulse rising strobe", n_rise, 1);
    pin = 1'b0;
    watch(24);
    check("R4 long pulse falling strobe", n_rise, 1);
    check("R4 long pulse level back low", level_o, 0);

    run = 1'b0; slow = 1'b1; cap = 1'b0; sel = 2'b11;
    watch(6);
    run = 1'b1;
    watch(8);
    pin = 1'b1; tick(); tick(); pin = 1'b0;
    watch(12);
    check("R5 count mode passes short pulse", n_rise, 2);
    check("R3 count mode pulse widths", n_high, 2);

    ofn = 1'b1;
    tick();
    held = level_o;
    pin = 1'b1; watch(6);
    pin = 1'b0; watch(6);
    pin = 1'b1; watch(6);
    check("R8 output function strobes", n_high, 0);
    check("R8 output function level", level_o, held);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule